// File: doc/BRIEF.md
# Display Identification Responder on the Display Data Channel

This block is the display-side responder on the two-wire display data channel. A video source reads the display's identification bytes through it. The bytes live in an internal byte store. After reset, local logic fills that store through a simple parallel write port. The store is split into 256-byte segments, and each segment holds two 128-byte identification blocks.

The data target answers at 7-bit address 0x50, which is 0xA0 for a write and 0xA1 for a read. A write to it sets an 8-bit word offset. A read returns bytes starting at that offset, and the offset advances after every byte the source acknowledges. The source can use an offset write, then a repeated START, then a read (a random read). It can also read on from wherever the offset was left (a sequential read).

A second, write-only target at 7-bit address 0x30 holds a segment pointer. The pointer selects which 256-byte window the data target exposes, so blocks beyond the first two can be reached. The pointer lasts only until the next STOP.

The design samples SCL and SDA with the system clock, which must run well above the bus bit rate. It drives SDA through a single pull-low enable. The pad driver, clock stretching and hot-plug signalling sit outside the block.

Top module: `edid_ddc_target`

## Requirements
- R1: After reset, SDA is released, the segment pointer is 0 and the word offset is 0. A read issued with no offset write therefore returns the byte at store address 0.
- R2: The block ACKs address byte 0xA0 (write) and 0xA1 (read) to target 0x50, and address byte 0x60 (write) to target 0x30. It NACKs every other address byte, including 0x61 (a read to 0x30). After a NACKed address, SDA stays released until the next START or STOP.
- R3: A random read returns the byte at store address {segment, offset}: write 0xA0, write the offset, send a repeated START, then send 0xA1.
- R4: During a read, the offset increases by one after each byte the master ACKs, so a sequential read runs straight across the boundary from offset 0x7F to 0x80.
- R5: The offset wraps from 0xFF to 0x00 inside the current segment; the segment does not change.
- R6: The first data byte written to target 0x30 sets the segment. Only its low SEG_BITS bits are used, so with the default SEG_BITS = 2, segment 5 selects segment 1.
- R7: In one transaction, target 0x30 accepts only one data byte, and target 0x50 accepts only one offset byte. Any further write byte is NACKed and leaves the segment or offset unchanged.
- R8: A STOP sets the segment pointer back to 0. A repeated START keeps it. The word offset is kept across both STOP and repeated START.
- R9: When the master NACKs a read byte, the block releases SDA and drives nothing until the next START or STOP. The offset does not advance for that byte.
- R10: When ld_we is high at a clock edge, ld_data is written to store address ld_addr.
- R11: The block changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run much faster than SCL. |
| rst_n | input | 1 | Synchronous reset, active low. |
| scl_i | input | 1 | SCL level as seen at the pad. |
| sda_i | input | 1 | SDA level as seen at the pad. |
| sda_pull_o | output | 1 | When high, the pad driver pulls SDA low. |
| ld_we | input | 1 | Write enable for the byte store. |
| ld_addr | input | SEG_BITS+8 (10) | Byte store write address, as {segment, offset}. |
| ld_data | input | 8 | Byte written into the store. |

## Verification
Some behaviours are checked by assertions on every cycle:
- SDA moves only while SCL is low.
- The block holds SDA released while idle and after a master NACK.
- A STOP clears the segment pointer.
- Each ACKed read byte advances the offset by exactly one.
- A second write byte to the segment target is refused and leaves the segment unchanged.

Other behaviours only the bench scenarios can show, because each needs a whole bus transaction and a known store content:
- Which bytes come back across the 0x7F/0x80 boundary and the wrap inside a segment.
- How the segment pointer maps to store addresses, including the modulo behaviour of R6.
- That the segment resets after a STOP while the offset survives.
- Where the offset stands after a master NACK.

// File: rtl/edid_pkg.sv
// Shared definitions for the display identification responder.
// Assumes 7-bit addressing on the two-wire bus.
package edid_pkg;
    localparam logic [6:0] DATA_TARGET_ADDR = 7'h50;
    localparam logic [6:0] SEG_TARGET_ADDR  = 7'h30;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not yet started
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // ninth clock of an address or write byte
        ST_WDATA,  // shifting in a write data byte
        ST_RDATA,  // shifting out a read data byte
        ST_RACK,   // ninth clock of a read byte, master answers
        ST_HOLD    // not addressed or read ended, wait for START/STOP
    } bus_st_t;

    typedef enum logic {
        TGT_DATA,
        TGT_SEG
    } tgt_t;
endpackage

// File: rtl/edid_line_sync.sv
// Brings one bus line into the clk domain and flags its edges.
// Assumes the line is idle high, so the flops reset to 1.
module edid_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [2:0] sh_q;

    // Two-flop synchronizer followed by one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= {sh_q[1:0], pin};
    end

    assign level = sh_q[1];
    assign rise  = sh_q[1] & ~sh_q[2];
    assign fall  = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/edid_byte_store.sv
// Identification byte store: one write port, one asynchronous read port.
// Assumes the local loader fills it before any bus master reads it; it has no reset.
module edid_byte_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    // Loader write port (R10).
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/edid_bus_engine.sv
// Target protocol engine: address match, offset and segment capture,
// read shifting and ACK handling.
// Assumes synchronized SCL and SDA with single-cycle edge strobes.
// It drives SDA only through the pull enable, and only while SCL is low.
module edid_bus_engine
    import edid_pkg::*;
#(
    parameter int SEG_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_lvl,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_lvl,
    input  logic                  sda_rise,
    input  logic                  sda_fall,
    input  logic [7:0]            rd_data,
    output logic [SEG_BITS+7:0]   rd_addr,
    output logic                  sda_pull
);
    bus_st_t             state_q;
    tgt_t                tgt_q;
    logic [3:0]          cnt_q;
    logic [7:0]          shift_q;
    logic [7:0]          tx_q;
    logic [7:0]          off_q;
    logic [SEG_BITS-1:0] seg_q;
    logic                rd_q, off_done_q, seg_done_q, ack_q, from_addr_q, mack_q;
    logic                start_c, stop_c, evt_c;

    assign start_c = sda_fall & scl_lvl;
    assign stop_c  = sda_rise & scl_lvl;
    assign evt_c   = ~start_c & ~stop_c;
    assign rd_addr = {seg_q, off_q};

    // Bus protocol state machine; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tgt_q       <= TGT_DATA;
            cnt_q       <= '0;
            shift_q     <= '0;
            tx_q        <= '0;
            off_q       <= '0;
            seg_q       <= '0;
            rd_q        <= 1'b0;
            off_done_q  <= 1'b0;
            seg_done_q  <= 1'b0;
            ack_q       <= 1'b0;
            from_addr_q <= 1'b0;
            mack_q      <= 1'b0;
            sda_pull    <= 1'b0;
        end else if (start_c) begin
            state_q  <= ST_ADDR;
            cnt_q    <= '0;
            sda_pull <= 1'b0;
        end else if (stop_c) begin
            state_q  <= ST_IDLE;
            seg_q    <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shift_q <= {shift_q[6:0], sda_lvl};
                        cnt_q   <= cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        state_q     <= ST_ACK;
                        from_addr_q <= (state_q == ST_ADDR);
                        if (state_q == ST_ADDR) begin
                            if (shift_q[7:1] == DATA_TARGET_ADDR) begin
                                ack_q      <= 1'b1;
                                sda_pull   <= 1'b1;
                                tgt_q      <= TGT_DATA;
                                rd_q       <= shift_q[0];
                                off_done_q <= 1'b0;
                            end else if (shift_q[7:1] == SEG_TARGET_ADDR && !shift_q[0]) begin
                                ack_q      <= 1'b1;
                                sda_pull   <= 1'b1;
                                tgt_q      <= TGT_SEG;
                                rd_q       <= 1'b0;
                                seg_done_q <= 1'b0;
                            end else begin
                                ack_q <= 1'b0;
                            end
                        end else if (tgt_q == TGT_SEG && !seg_done_q) begin
                            ack_q      <= 1'b1;
                            sda_pull   <= 1'b1;
                            seg_q      <= shift_q[SEG_BITS-1:0];
                            seg_done_q <= 1'b1;
                        end else if (tgt_q == TGT_DATA && !off_done_q) begin
                            ack_q      <= 1'b1;
                            sda_pull   <= 1'b1;
                            off_q      <= shift_q;
                            off_done_q <= 1'b1;
                        end else begin
                            ack_q <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (!ack_q) begin
                            sda_pull <= 1'b0;
                            state_q  <= ST_HOLD;
                        end else if (from_addr_q && rd_q) begin
                            tx_q     <= rd_data;
                            sda_pull <= ~rd_data[7];
                            state_q  <= ST_RDATA;
                        end else begin
                            sda_pull <= 1'b0;
                            state_q  <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == 4'd7) begin
                            sda_pull <= 1'b0;
                            state_q  <= ST_RACK;
                        end else begin
                            tx_q     <= {tx_q[6:0], 1'b0};
                            sda_pull <= ~tx_q[6];
                            cnt_q    <= cnt_q + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                        if (!sda_lvl) off_q <= off_q + 8'd1;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_q     <= rd_data;
                            sda_pull <= ~rd_data[7];
                            cnt_q    <= '0;
                            state_q  <= ST_RDATA;
                        end else begin
                            state_q  <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: the pull enable may change only while SCL is low.
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    // R8: a STOP leaves the segment pointer at zero.
    a_r8_stop_clears_seg: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (seg_q == '0));

    // R4: an ACKed read byte advances the offset by exactly one.
    a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && scl_rise && !sda_lvl && evt_c) |=> (off_q == $past(off_q) + 8'd1));

    // R9: after a master NACK or an unmatched address, SDA stays released.
    a_r9_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !sda_pull);

    // R2: an idle bus is never pulled.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull);

    // R7: a second byte to the segment target is refused and leaves the segment unchanged.
    a_r7_seg_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA && scl_fall && cnt_q == 4'd8 && tgt_q == TGT_SEG && seg_done_q && evt_c)
        |=> (!sda_pull && seg_q == $past(seg_q)));
endmodule

// File: rtl/edid_ddc_target.sv
// Top of the display identification responder.
// Joins the line synchronizers, the byte store and the protocol engine.
// Assumes clk runs well above the SCL rate and that the pad inverts sda_pull_o.
module edid_ddc_target #(
    parameter int SEG_BITS = 2,
    localparam int MEM_AW  = SEG_BITS + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              ld_we,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;

    edid_line_sync u_scl_sync (
        .clk(clk), .rst_n(rst_n), .pin(scl_i),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    edid_line_sync u_sda_sync (
        .clk(clk), .rst_n(rst_n), .pin(sda_i),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    edid_byte_store #(.AW(MEM_AW)) u_store (
        .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    edid_bus_engine #(.SEG_BITS(SEG_BITS)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_data(rd_data), .rd_addr(rd_addr), .sda_pull(sda_pull_o)
    );
endmodule

// File: tb/edid_ddc_target_tb.sv
// Bit-level bus master bench for edid_ddc_target.
// Expected bytes come from a formula over the store address.
module edid_ddc_target_tb;
    localparam int SEG_BITS = 2;
    localparam int AW = SEG_BITS + 8;
    localparam int T  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic sda_pull;
    logic sda_line;
    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    edid_ddc_target #(.SEG_BITS(SEG_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + ((a >> 8) * 101) + 5);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(T);
        scl = 1'b1;   tick(T);
        sda_m = 1'b0; tick(T);
        scl = 1'b0;   tick(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(T);
        scl = 1'b1;   tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic wr(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(T);
            scl = 1'b1;   tick(T);
            scl = 1'b0;   tick(T);
        end
        sda_m = 1'b1; tick(T);
        scl = 1'b1;   tick(T);
        ack = ~sda_line;
        scl = 1'b0;   tick(T);
    endtask

    task automatic rd(input logic give_ack, output logic [7:0] b);
        logic s1, s2;
        logic stable_ok = 1'b1;
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(T);
            scl = 1'b1; tick(T / 2);
            s1 = sda_line; tick(T / 2);
            s2 = sda_line;
            if (s1 != s2) stable_ok = 1'b0;
            b = {b[6:0], s1};
            scl = 1'b0;
        end
        chk(stable_ok, "R11 sda stable while scl high", 0, 0);
        sda_m = give_ack ? 1'b0 : 1'b1; tick(T);
        scl = 1'b1; tick(T);
        scl = 1'b0; tick(T / 2);
        sda_m = 1'b1; tick(T / 2);
    endtask

    // Writes the optional segment and then the offset, and reads n bytes, NACKing the last.
    task automatic seq_read(input logic use_seg, input logic [7:0] seg, input int off,
                            input int n, input int base_addr, input string tag);
        logic a;
        logic [7:0] b;
        bus_start();
        if (use_seg) begin
            wr(8'h60, a); chk(a, {tag, " seg addr ack"}, a, 1);
            wr(seg, a);   chk(a, {tag, " seg byte ack"}, a, 1);
            bus_start();
        end
        wr(8'hA0, a);      chk(a, {tag, " addr A0 ack"}, a, 1);
        wr(8'(off), a);    chk(a, {tag, " offset ack"}, a, 1);
        bus_start();
        wr(8'hA1, a);      chk(a, {tag, " addr A1 ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            int ea;
            ea = base_addr + ((off + k) % 256);
            rd(k != n - 1, b);
            chk(b == pat(ea), tag, b, pat(ea));
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk(sda_pull == 1'b0, "R1 sda released after reset", sda_pull, 0);

        for (int i = 0; i < (1 << AW); i++) begin
            ld_we = 1'b1; ld_addr = AW'(i); ld_data = pat(i);
            tick(1);
        end
        ld_we = 1'b0;
        tick(T);

        // R1 and R10: a read with no offset write starts at store address 0.
        bus_start();
        wr(8'hA1, a); chk(a, "R1 read addr ack", a, 1);
        rd(1'b0, b);  chk(b == pat(0), "R1 R10 first byte", b, pat(0));
        bus_stop();

        // R2: address filtering.
        bus_start(); wr(8'h6E, a); chk(!a, "R2 0x37 nack", a, 0);
        chk(sda_pull == 1'b0, "R2 released after nack", sda_pull, 0); bus_stop();
        bus_start(); wr(8'hA2, a); chk(!a, "R2 0x51 nack", a, 0); bus_stop();
        bus_start(); wr(8'h61, a); chk(!a, "R2 0x30 read nack", a, 0); bus_stop();

        // R4 R5 R10: sweep all of segment 0 and wrap to offset 1.
        seq_read(1'b0, 8'h00, 0, 258, 0, "R4 R5 R10 sweep seg0");
        chk(sda_pull == 1'b0, "R9 released after master nack", sda_pull, 0);

        // R9: the NACKed byte did not advance the offset, so a plain read gives offset 1 again.
        bus_start();
        wr(8'hA1, a); chk(a, "R9 read addr ack", a, 1);
        rd(1'b0, b);  chk(b == pat(1), "R9 offset held after nack", b, pat(1));
        bus_stop();

        // R3: random reads at chosen offsets.
        seq_read(1'b0, 8'h00, 8'h7F, 2, 0, "R3 R4 off7F");
        seq_read(1'b0, 8'h00, 8'hFF, 1, 0, "R3 offFF");
        seq_read(1'b0, 8'h00, 8'h3C, 1, 0, "R3 off3C");

        // R6 R5: segment selection and wrap inside a segment.
        seq_read(1'b1, 8'h01, 8'h10, 3, 256, "R6 seg1");
        seq_read(1'b1, 8'h03, 8'hFE, 4, 768, "R6 R5 seg3 wrap");
        seq_read(1'b1, 8'h05, 8'h20, 1, 256, "R6 seg5 modulo");

        // R8: after a STOP the segment is back to 0; the offset survives the STOP.
        seq_read(1'b0, 8'h00, 8'h10, 1, 0, "R8 seg cleared by stop");
        bus_start();
        wr(8'hA1, a); chk(a, "R8 read addr ack", a, 1);
        rd(1'b0, b);  chk(b == pat(8'h10), "R8 offset kept over stop", b, pat(8'h10));
        bus_stop();

        // R7: extra write bytes are refused and change nothing.
        bus_start();
        wr(8'h60, a); chk(a, "R7 seg addr ack", a, 1);
        wr(8'h02, a); chk(a, "R7 seg byte ack", a, 1);
        wr(8'h03, a); chk(!a, "R7 second seg byte nack", a, 0);
        bus_start();
        wr(8'hA0, a); chk(a, "R7 A0 ack", a, 1);
        wr(8'h05, a); chk(a, "R7 offset ack", a, 1);
        wr(8'h06, a); chk(!a, "R7 second offset nack", a, 0);
        bus_start();
        wr(8'hA1, a); chk(a, "R7 A1 ack", a, 1);
        rd(1'b0, b);  chk(b == pat(12'h205), "R7 seg and offset unchanged", b, pat(12'h205));
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule